// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block is the combinational part of the execute stage of a 32-bit load/store core. It receives one decoded instruction: its kind, an ALU function code, a branch condition code, two register operand values, an optional immediate, the address of the instruction and the address that fetch guessed would come next. It returns the ALU result, the value to write back, the memory address, a taken flag, the resolved next PC and a flag that marks a wrong guess by fetch.

The pipeline control around the block uses the mispredict flag to discard the wrong-path instruction and to steer fetch to the resolved next PC. The block has no state. It spends no cycles: every output follows its inputs within the same cycle.

Top module: `exu_resolve`

## Requirements
- R1: The second ALU operand is `imm` when `imm_vld` is 1, and `rs2_val` when `imm_vld` is 0.
- R2: `alu_res` follows `alu_op`. 0 is add, 1 is subtract (op1-op2), 2 is AND, 3 is OR and 4 is XOR. 5 gives 1 when op1 < op2 signed and 0 otherwise. 6 does the same comparison unsigned. 7 shifts op1 left by op2[4:0].
- R3: `br_cond` selects the branch condition. 0 means rs1==rs2 and 1 means rs1!=rs2. For 2 to 5, rs1 is read as signed and tested against zero: 2 is <0, 3 is <=0, 4 is >0 and 5 is >=0. Codes 6 and 7 are never taken.
- R4: A direct jump (`kind`=3) goes to {(pc+4)[31:28], imm[27:0]}. The upper four bits come from pc+4, not from pc.
- R5: A register jump (`kind`=4) goes to `rs1_val`.
- R6: A conditional branch (`kind`=5) goes to pc+4+imm when its condition holds, and to pc+4 otherwise. Both sums wrap modulo 2^32.
- R7: The ALU kind (0), load (1), store (2) and the unsupported kinds (6, 7) all go to pc+4.
- R8: `wb_data` is `rs2_val` for a store, pc+4 for either jump kind, and `alu_res` for every other kind.
- R9: `mem_addr` is `alu_res` for a load or a store. For every other kind it is the resolved next PC.
- R10: `taken` is 1 for both jump kinds. For a branch it is the value of the condition. For every other kind it is 0.
- R11: `mispredict` is 1 exactly when `next_pc` differs from `pred_pc`.
- R12: `dst_vld` is 0 for the unsupported kinds (6, 7). For every other kind it equals `dst_vld_in`. `dst_idx` always equals `dst_idx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind | input | 3 | Decoded instruction kind |
| alu_op | input | 3 | ALU function code |
| br_cond | input | 3 | Branch condition code |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| imm_vld | input | 1 | Immediate present |
| imm | input | 32 | Immediate value (byte offset for branches) |
| pc | input | 32 | Address of this instruction |
| pred_pc | input | 32 | Next address guessed by fetch |
| dst_vld_in | input | 1 | Decoded destination valid |
| dst_idx_in | input | 5 | Decoded destination index |
| alu_res | output | 32 | ALU result |
| wb_data | output | 32 | Value for writeback or store data |
| mem_addr | output | 32 | Memory address or branch target |
| taken | output | 1 | Control transfer taken |
| next_pc | output | 32 | Resolved next PC |
| mispredict | output | 1 | Fetch guess was wrong |
| dst_vld | output | 1 | Destination valid after execute |
| dst_idx | output | 5 | Destination index |

## Verification
Two situations are rare under plain random stimulus and are therefore built on purpose.

The first is a direct jump from the last word of a 256 MB region. There pc+4 carries into bit 28, so the region bits of the target differ from those of the instruction's own PC. The bench places PCs at such boundaries, including 0xFFFFFFFC, where pc+4 wraps to zero.

The second is a correctly guessed next PC. A random `pred_pc` almost never equals the resolved address. For about half of the random vectors, the bench therefore sets `pred_pc` from its own model's resolved PC, so that both values of `mispredict` are exercised. Signed conditions are also driven at zero, -1 and the most negative value.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int unsigned CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        K_ALU   = 3'd0,
        K_LOAD  = 3'd1,
        K_STORE = 3'd2,
        K_JDIR  = 3'd3,
        K_JREG  = 3'd4,
        K_BR    = 3'd5,
        K_RSV6  = 3'd6,
        K_RSV7  = 3'd7
    } kind_e;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SLT  = 3'd5,
        OP_SLTU = 3'd6,
        OP_SLL  = 3'd7
    } alu_op_e;

    typedef enum logic [CODE_W-1:0] {
        C_EQ   = 3'd0,
        C_NE   = 3'd1,
        C_LTZ  = 3'd2,
        C_LEZ  = 3'd3,
        C_GTZ  = 3'd4,
        C_GEZ  = 3'd5,
        C_NV6  = 3'd6,
        C_NV7  = 3'd7
    } cond_e;

    function automatic logic kind_is_mem(kind_e k);
        return (k == K_LOAD) || (k == K_STORE);
    endfunction

    function automatic logic kind_is_jump(kind_e k);
        return (k == K_JDIR) || (k == K_JREG);
    endfunction

    function automatic logic kind_is_unsup(kind_e k);
        return (k == K_RSV6) || (k == K_RSV7);
    endfunction

endpackage

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);
    localparam int unsigned SH_W = $clog2(XLEN);

    logic [SH_W-1:0] shamt;
    logic            lt_s;
    logic            lt_u;

    assign shamt = b[SH_W-1:0];
    assign lt_s  = $signed(a) < $signed(b);
    assign lt_u  = a < b;

    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SLT:  res = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: res = {{(XLEN-1){1'b0}}, lt_u};
            OP_SLL:  res = a << shamt;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/exu_brcond.sv
module exu_brcond
    import exu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit
);
    logic eq;
    logic neg;
    logic zero;

    assign eq   = (a == b);
    assign neg  = a[XLEN-1];
    assign zero = (a == '0);

    always_comb begin
        unique case (cond)
            C_EQ:    hit = eq;
            C_NE:    hit = !eq;
            C_LTZ:   hit = neg;
            C_LEZ:   hit = neg || zero;
            C_GTZ:   hit = !neg && !zero;
            C_GEZ:   hit = !neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/exu_target.sv
module exu_target
    import exu_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned REGION_W = 4
) (
    input  kind_e           kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] imm,
    input  logic            cond_hit,
    output logic [XLEN-1:0] pc_seq,
    output logic [XLEN-1:0] next_pc,
    output logic            taken
);
    localparam int unsigned LOW_W = XLEN - REGION_W;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] jdir_tgt;
    logic [XLEN-1:0] br_tgt;

    assign pc_seq = pc + STEP;
    assign br_tgt = pc_seq + imm;

    generate
        if (REGION_W == 0) begin : g_flat
            assign jdir_tgt = imm;
        end else begin : g_region
            assign jdir_tgt = {pc_seq[XLEN-1:LOW_W], imm[LOW_W-1:0]};
        end
    endgenerate

    always_comb begin
        unique case (kind)
            K_JDIR: begin next_pc = jdir_tgt; taken = 1'b1;     end
            K_JREG: begin next_pc = rs1;      taken = 1'b1;     end
            K_BR:   begin next_pc = cond_hit ? br_tgt : pc_seq;
                          taken   = cond_hit;                   end
            default: begin next_pc = pc_seq;  taken = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/exu_resolve.sv
module exu_resolve
    import exu_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned REGION_W = 4,
    parameter int unsigned IDX_W    = 5
) (
    input  logic [2:0]       kind,
    input  logic [2:0]       alu_op,
    input  logic [2:0]       br_cond,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic             imm_vld,
    input  logic [XLEN-1:0]  imm,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  pred_pc,
    input  logic             dst_vld_in,
    input  logic [IDX_W-1:0] dst_idx_in,
    output logic [XLEN-1:0]  alu_res,
    output logic [XLEN-1:0]  wb_data,
    output logic [XLEN-1:0]  mem_addr,
    output logic             taken,
    output logic [XLEN-1:0]  next_pc,
    output logic             mispredict,
    output logic             dst_vld,
    output logic [IDX_W-1:0] dst_idx
);
    kind_e           k;
    logic [XLEN-1:0] op2;
    logic            hit;
    logic [XLEN-1:0] pc_seq;

    assign k   = kind_e'(kind);
    assign op2 = imm_vld ? imm : rs2_val;

    exu_alu #(.XLEN(XLEN)) u_alu (
        .op  (alu_op_e'(alu_op)),
        .a   (rs1_val),
        .b   (op2),
        .res (alu_res)
    );

    exu_brcond #(.XLEN(XLEN)) u_cond (
        .cond (cond_e'(br_cond)),
        .a    (rs1_val),
        .b    (rs2_val),
        .hit  (hit)
    );

    exu_target #(.XLEN(XLEN), .REGION_W(REGION_W)) u_tgt (
        .kind     (k),
        .pc       (pc),
        .rs1      (rs1_val),
        .imm      (imm),
        .cond_hit (hit),
        .pc_seq   (pc_seq),
        .next_pc  (next_pc),
        .taken    (taken)
    );

    always_comb begin
        if (k == K_STORE)          wb_data = rs2_val;
        else if (kind_is_jump(k))  wb_data = pc_seq;
        else                       wb_data = alu_res;
    end

    assign mem_addr   = kind_is_mem(k) ? alu_res : next_pc;
    assign mispredict = (next_pc != pred_pc);
    assign dst_vld    = dst_vld_in && !kind_is_unsup(k);
    assign dst_idx    = dst_idx_in;
endmodule

// File: rtl/exu_resolve_chk.sv
module exu_resolve_chk #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned REGION_W = 4,
    parameter int unsigned IDX_W    = 5
) (
    input logic [2:0]      kind,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] pred_pc,
    input logic [XLEN-1:0] alu_res,
    input logic [XLEN-1:0] wb_data,
    input logic [XLEN-1:0] mem_addr,
    input logic            taken,
    input logic [XLEN-1:0] next_pc,
    input logic            mispredict,
    input logic            dst_vld
);
    localparam int unsigned LOW_W = XLEN - REGION_W;
    logic [XLEN-1:0] seq;
    assign seq = pc + XLEN'(4);

    always_comb begin
        if (kind == 3'd3)
            a_r4_region_from_seq: assert (next_pc[XLEN-1:LOW_W] == seq[XLEN-1:LOW_W]);
        if (kind == 3'd4)
            a_r5_reg_jump: assert (next_pc == rs1_val);
        if (kind <= 3'd2 || kind >= 3'd6)
            a_r7_sequential: assert (next_pc == seq);
        if (kind == 3'd2)
            a_r8_store_data: assert (wb_data == rs2_val);
        if (kind == 3'd1 || kind == 3'd2)
            a_r9_mem_addr: assert (mem_addr == alu_res);
        if (kind == 3'd3 || kind == 3'd4)
            a_r10_jump_taken: assert (taken);
        if (!mispredict)
            a_r11_match: assert (next_pc == pred_pc);
        if (kind >= 3'd6)
            a_r12_unsup: assert (!dst_vld && !taken);
    end
endmodule

bind exu_resolve exu_resolve_chk #(
    .XLEN(XLEN), .REGION_W(REGION_W), .IDX_W(IDX_W)
) u_chk (
    .kind(kind), .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc),
    .pred_pc(pred_pc), .alu_res(alu_res), .wb_data(wb_data),
    .mem_addr(mem_addr), .taken(taken), .next_pc(next_pc),
    .mispredict(mispredict), .dst_vld(dst_vld)
);

// File: tb/tb_exu_resolve.sv
module tb_exu_resolve;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0]  kind, alu_op, br_cond;
    logic [31:0] rs1_val, rs2_val, imm, pc, pred_pc;
    logic        imm_vld, dst_vld_in;
    logic [4:0]  dst_idx_in;
    logic [31:0] alu_res, wb_data, mem_addr, next_pc;
    logic        taken, mispredict, dst_vld;
    logic [4:0]  dst_idx;

    exu_resolve dut (
        .kind(kind), .alu_op(alu_op), .br_cond(br_cond),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_vld(imm_vld), .imm(imm),
        .pc(pc), .pred_pc(pred_pc), .dst_vld_in(dst_vld_in),
        .dst_idx_in(dst_idx_in), .alu_res(alu_res), .wb_data(wb_data),
        .mem_addr(mem_addr), .taken(taken), .next_pc(next_pc),
        .mispredict(mispredict), .dst_vld(dst_vld), .dst_idx(dst_idx)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected values, recomputed from the requirement text.
    logic [31:0] e_alu, e_wb, e_addr, e_next;
    logic        e_taken, e_mis, e_dvld;

    function automatic logic [31:0] ref_alu(input logic [2:0] op,
                                            input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return (sa < sb) ? 32'd1 : 32'd0;
            3'd6: return ({1'b0, a} < {1'b0, b}) ? 32'd1 : 32'd0;
            default: return a << b[4:0];
        endcase
    endfunction

    function automatic logic ref_cond(input logic [2:0] c,
                                      input logic [31:0] a, input logic [31:0] b);
        int sa = $signed(a);
        case (c)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return sa < 0;
            3'd3: return sa <= 0;
            3'd4: return sa > 0;
            3'd5: return sa >= 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model();
        logic [31:0] op2 = imm_vld ? imm : rs2_val;
        logic [31:0] p4  = pc + 32'd4;
        logic        c   = ref_cond(br_cond, rs1_val, rs2_val);
        e_alu = ref_alu(alu_op, rs1_val, op2);
        case (kind)
            3'd3: begin e_next = {p4[31:28], imm[27:0]}; e_taken = 1; end
            3'd4: begin e_next = rs1_val; e_taken = 1; end
            3'd5: begin e_next = c ? p4 + imm : p4; e_taken = c; end
            default: begin e_next = p4; e_taken = 0; end
        endcase
        if (kind == 3'd2) e_wb = rs2_val;
        else if (kind == 3'd3 || kind == 3'd4) e_wb = p4;
        else e_wb = e_alu;
        e_addr = (kind == 3'd1 || kind == 3'd2) ? e_alu : e_next;
        e_mis  = (e_next != pred_pc);
        e_dvld = dst_vld_in && (kind < 3'd6);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s kind=%0d act=%h exp=%h", tag, kind, act, exp);
        end
    endtask

    task automatic compare_all();
        string ntag;
        model();
        case (kind)
            3'd3: ntag = "R4 next_pc";
            3'd4: ntag = "R5 next_pc";
            3'd5: ntag = "R6 next_pc";
            default: ntag = "R7 next_pc";
        endcase
        chk("R1 R2 alu_res", alu_res, e_alu);
        chk(ntag, next_pc, e_next);
        chk("R8 wb_data", wb_data, e_wb);
        chk("R9 mem_addr", mem_addr, e_addr);
        chk((kind == 3'd5) ? "R3 R10 taken" : "R10 taken", {31'd0, taken}, {31'd0, e_taken});
        chk("R11 mispredict", {31'd0, mispredict}, {31'd0, e_mis});
        chk("R12 dst_vld", {31'd0, dst_vld}, {31'd0, e_dvld});
        chk("R12 dst_idx", {27'd0, dst_idx}, {27'd0, dst_idx_in});
    endtask

    // Drive a quarter period after the rising edge, compare at the falling edge.
    task automatic apply(input logic [2:0] k, input logic [2:0] op, input logic [2:0] c,
                         input logic [31:0] a, input logic [31:0] b, input logic iv,
                         input logic [31:0] im, input logic [31:0] p, input logic [31:0] pp,
                         input logic dv);
        @(posedge clk);
        #(CLK_PERIOD/4);
        kind = k; alu_op = op; br_cond = c; rs1_val = a; rs2_val = b;
        imm_vld = iv; imm = im; pc = p; pred_pc = pp; dst_vld_in = dv;
        dst_idx_in = a[4:0] ^ b[9:5];
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        kind = 0; alu_op = 0; br_cond = 0; rs1_val = 0; rs2_val = 0; imm_vld = 0;
        imm = 0; pc = 0; pred_pc = 0; dst_vld_in = 0; dst_idx_in = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: all-zero inputs resolve to PC+4 = 4.
        @(negedge clk);
        chk("R7 idle next_pc", next_pc, 32'd4);
        chk("R11 idle mispredict", {31'd0, mispredict}, 32'd1);

        // R1: immediate versus register as second operand
        apply(3'd0, 3'd0, 3'd0, 32'd10, 32'd5, 1'b0, 32'd100, 32'h1000, 32'h1004, 1'b1);
        apply(3'd0, 3'd0, 3'd0, 32'd10, 32'd5, 1'b1, 32'd100, 32'h1000, 32'h1004, 1'b1);
        // R2: signed vs unsigned less-than, shift
        apply(3'd0, 3'd5, 3'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 0, 32'h40, 32'h44, 1'b1);
        apply(3'd0, 3'd6, 3'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 0, 32'h40, 32'h44, 1'b1);
        apply(3'd0, 3'd7, 3'd0, 32'h1, 32'h23, 1'b0, 0, 32'h40, 32'h44, 1'b1);
        // R3: conditions at zero, -1 and most negative
        for (int c = 0; c < 8; c++) begin
            apply(3'd5, 3'd0, 3'(c), 32'd0, 32'd0, 1'b1, 32'hFFFF_FFF0, 32'h200, 32'h204, 1'b0);
            apply(3'd5, 3'd0, 3'(c), 32'hFFFF_FFFF, 32'd7, 1'b1, 32'h10, 32'h200, 32'h214, 1'b0);
            apply(3'd5, 3'd0, 3'(c), 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h10, 32'h200, 32'h214, 1'b0);
        end
        // R4: region bits come from PC+4, including wrap at the top
        apply(3'd3, 3'd0, 3'd0, 0, 0, 1'b1, 32'hFABC_DEF0, 32'h0FFF_FFFC, 32'h0ABC_DEF0, 1'b1);
        apply(3'd3, 3'd0, 3'd0, 0, 0, 1'b1, 32'h0123_4560, 32'hFFFF_FFFC, 32'h0, 1'b1);
        // R5: register jump
        apply(3'd4, 3'd0, 3'd0, 32'hDEAD_BEE0, 0, 1'b0, 0, 32'h300, 32'hDEAD_BEE0, 1'b1);
        // R6: branch wrapping below zero
        apply(3'd5, 3'd0, 3'd0, 32'd3, 32'd3, 1'b1, 32'hFFFF_FFE0, 32'h8, 32'h0, 1'b1);
        // R8, R9: load and store
        apply(3'd1, 3'd0, 3'd0, 32'h1000, 32'h55, 1'b1, 32'h20, 32'h400, 32'h404, 1'b1);
        apply(3'd2, 3'd0, 3'd0, 32'h1000, 32'h55, 1'b1, 32'h20, 32'h400, 32'h999, 1'b0);
        // R12: unsupported kinds drop the destination and the taken flag
        apply(3'd6, 3'd0, 3'd0, 32'h1, 32'h1, 1'b0, 0, 32'h500, 32'h504, 1'b1);
        apply(3'd7, 3'd0, 3'd0, 32'h1, 32'h1, 1'b0, 0, 32'h500, 32'h504, 1'b1);

        // Random mix; half of the vectors carry a correct guess.
        for (int n = 0; n < N_RAND; n++) begin
            logic [2:0] k = 3'($urandom_range(0, 7));
            logic [31:0] a = (n % 5 == 0) ? 32'd0 : $urandom;
            logic [31:0] b = (n % 7 == 0) ? a : $urandom;
            logic [31:0] p = {$urandom, 2'b00} >> 0;
            @(posedge clk);
            #(CLK_PERIOD/4);
            kind = k; alu_op = 3'($urandom); br_cond = 3'($urandom);
            rs1_val = a; rs2_val = b; imm_vld = 1'($urandom); imm = $urandom;
            pc = {p[31:2], 2'b00}; dst_vld_in = 1'($urandom); dst_idx_in = 5'($urandom);
            pred_pc = $urandom;
            if (n % 2 == 0) begin
                model();
                pred_pc = e_next;
            end
            @(negedge clk);
            compare_all();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule